// File: doc/BRIEF.md
# Rate-Select Divider with Update-in-Progress Warning

This block sits at the base of a real-time clock. It takes a 32.768 kHz clock enable on a faster system clock and counts it through a 15-stage binary chain. A three-bit oscillator field decides whether the chain runs, is held at zero, or is frozen with the oscillator stopped. A four-bit rate code selects one of thirteen chain taps through a sixteen-way selector. That tap drives both a gated square-wave output and a one-cycle periodic event pulse. Code zero gives no tap.

The chain wraps once per second. The cycle in which it wraps is the update transfer, and a strobe marks it for the calendar logic. Eight ticks (about 244 µs) before that transfer, a warning bit goes high. It stays high through the transfer cycle. One system cycle after each transfer, an update-ended pulse is issued for the interrupt flag logic. A hold input stops transfers so that software can load the time, and it also forces the warning bit low. When the run code is newly written, the chain restarts at its midpoint, so the first transfer comes half a second later.

All outputs are registered. An input sampled at a rising clock edge shows at the outputs just after that same edge.

Top module: `rate_div_uip`

## Requirements
- R1: Oscillator field `osc_ctl` = 3'b010 runs the chain. 3'b110 and 3'b111 hold the chain at zero, so there is no square wave, no periodic pulse, no transfer and no warning. Every other value freezes the chain: the square-wave level stays constant, and there is no pulse, no transfer and no warning.
- R2: In the cycle the run code is first seen after another code (or after reset), the chain loads its midpoint 2^14. The first transfer strobe then comes exactly 16384 counted ticks later.
- R3: While running, `update_strobe` pulses for one cycle on every tick that wraps the chain from all ones to zero, which is once every 32768 ticks.
- R4: Rate code `rate_sel` picks a chain bit. Bit k toggles at 32768/2^(k+1) Hz. Code 1 gives 256 Hz (bit 6). Code 2 gives 128 Hz (bit 7). Codes 3 to 15 give 2^(16-code) Hz (bit code-2), which runs from 8192 Hz down to 2 Hz. Code 0 gives a constant 0.
- R5: `periodic_pulse` is high for one cycle in each cycle where the selected tap goes from 0 to 1. That is one pulse per tap period, with periods from 4 ticks (122 µs) to 16384 ticks (500 ms).
- R6: `sqw` is 0 when `sqw_en` is 0. Otherwise it equals the selected tap level.
- R7: `update_in_progress` goes high when the chain reaches 32760, which is eight ticks before the wrap. It stays high up to and including the transfer cycle, and is 0 at all other times.
- R8: While `set_hold` is 1, there is no transfer strobe, no update-ended pulse, and `update_in_progress` is 0. The chain keeps counting.
- R9: `update_done` pulses for one cycle, in the cycle after each transfer strobe.
- R10: Synchronous active-high reset clears the chain and all five outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | 32.768 kHz clock enable, one cycle per tick |
| osc_ctl | input | 3 | Oscillator and chain control code |
| rate_sel | input | 4 | Tap select code |
| sqw_en | input | 1 | Square-wave output enable |
| set_hold | input | 1 | Inhibits update transfers and clears the warning |
| sqw | output | 1 | Gated square wave at the selected rate |
| periodic_pulse | output | 1 | One-cycle pulse on each rising edge of the selected tap |
| update_strobe | output | 1 | One-cycle update transfer strobe, once per second |
| update_in_progress | output | 1 | Warning that a transfer is at most eight ticks away |
| update_done | output | 1 | One-cycle update-ended pulse |

## Verification
Assertions check the following on every cycle:
- the square wave is low after a disabled cycle, and there is no pulse after code zero;
- there is no strobe or warning after a cycle with the hold input set;
- the warning covers every strobe, and the update-ended pulse follows every strobe;
- a held chain is at zero, and a frozen chain is stable;
- the chain is at its midpoint after a run entry.

Only the bench scenarios can show the following:
- the exact half-second and one-second distances between strobes;
- the exact eight-tick lead of the warning;
- the tap rates, measured as edge counts per window;
- behaviour with a gapped tick.

The bench shows these through a behavioural counter model compared on every clock.

// File: rtl/rdu_pkg.sv
package rdu_pkg;

  typedef enum logic [1:0] {
    OSC_STOP = 2'd0,
    OSC_HOLD = 2'd1,
    OSC_RUN  = 2'd2
  } osc_mode_e;

  // Chain bit carried by each non-zero rate code
  function automatic int tap_of(input int code);
    if (code == 1)      return 6;
    else if (code == 2) return 7;
    else                return code - 2;
  endfunction

endpackage

// File: rtl/rdu_mode_decode.sv
module rdu_mode_decode
  import rdu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] osc_ctl,
  output osc_mode_e  mode,
  output logic       run_entry
);

  logic run_q;

  always_comb begin
    casez (osc_ctl)
      3'b010:  mode = OSC_RUN;
      3'b11?:  mode = OSC_HOLD;
      default: mode = OSC_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= (mode == OSC_RUN);
  end

  assign run_entry = (mode == OSC_RUN) && !run_q;

  AST_ENTRY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    run_entry |=> !run_entry);  // R2

endmodule

// File: rtl/rdu_chain.sv
module rdu_chain
  import rdu_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  osc_mode_e         mode,
  input  logic              run_entry,
  output logic [STAGES-1:0] cnt_q,
  output logic [STAGES-1:0] cnt_nxt,
  output logic              wrap
);

  localparam logic [STAGES-1:0] MIDPOINT = {1'b1, {(STAGES-1){1'b0}}};

  always_comb begin
    cnt_nxt = cnt_q;
    wrap    = 1'b0;
    case (mode)
      OSC_HOLD: cnt_nxt = '0;
      OSC_RUN: begin
        if (run_entry) begin
          cnt_nxt = MIDPOINT;
        end else if (tick) begin
          cnt_nxt = cnt_q + 1'b1;
          wrap    = &cnt_q;
        end
      end
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  AST_HOLD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == OSC_HOLD) |=> (cnt_q == '0));  // R1
  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (mode == OSC_STOP) |=> $stable(cnt_q));  // R1
  AST_ENTRY_MIDPOINT: assert property (@(posedge clk) disable iff (rst)
    run_entry |=> (cnt_q == MIDPOINT));  // R2

endmodule

// File: rtl/rdu_tap_mux.sv
module rdu_tap_mux
  import rdu_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] cnt_q,
  input  logic [STAGES-1:0] cnt_nxt,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqw_en,
  output logic              sqw,
  output logic              periodic_pulse
);

  localparam int NCODES = 1 << RATE_W;

  logic [NCODES-1:0] tap_now;
  logic [NCODES-1:0] tap_old;
  logic              sel_now;
  logic              sel_old;

  for (genvar c = 0; c < NCODES; c++) begin : g_tap
    if (c == 0) begin : g_off
      assign tap_now[c] = 1'b0;
      assign tap_old[c] = 1'b0;
    end else begin : g_on
      localparam int TI = tap_of(c);
      assign tap_now[c] = cnt_nxt[TI];
      assign tap_old[c] = cnt_q[TI];
    end
  end

  assign sel_now = tap_now[rate_sel];
  assign sel_old = tap_old[rate_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      sqw            <= 1'b0;
      periodic_pulse <= 1'b0;
    end else begin
      sqw            <= sqw_en && sel_now;
      periodic_pulse <= sel_now && !sel_old;
    end
  end

  AST_SQW_LOW_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !sqw_en |=> !sqw);  // R6
  AST_NO_PULSE_CODE0: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == '0) |=> !periodic_pulse);  // R4

endmodule

// File: rtl/rdu_update_seq.sv
module rdu_update_seq #(
  parameter int STAGES   = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] cnt_nxt,
  input  logic              wrap,
  input  logic              running,
  input  logic              set_hold,
  output logic              update_strobe,
  output logic              update_in_progress,
  output logic              update_done
);

  localparam logic [STAGES-1:0] UIP_START = {STAGES{1'b1}} - STAGES'(UIP_LEAD - 1);

  logic warn_d;

  assign warn_d = !set_hold && running && ((cnt_nxt >= UIP_START) || wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      update_strobe      <= 1'b0;
      update_in_progress <= 1'b0;
      update_done        <= 1'b0;
    end else begin
      update_strobe      <= wrap && !set_hold;
      update_in_progress <= warn_d;
      update_done        <= update_strobe;
    end
  end

  AST_NO_STROBE_IN_SET: assert property (@(posedge clk) disable iff (rst)
    set_hold |=> !update_strobe);  // R8
  AST_NO_UIP_IN_SET: assert property (@(posedge clk) disable iff (rst)
    set_hold |=> !update_in_progress);  // R8
  AST_UIP_COVERS_STROBE: assert property (@(posedge clk) disable iff (rst)
    update_strobe |-> update_in_progress);  // R7
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    update_strobe |=> (update_done && !update_strobe));  // R9

endmodule

// File: rtl/rate_div_uip.sv
module rate_div_uip
  import rdu_pkg::*;
#(
  parameter int STAGES   = 15,
  parameter int RATE_W   = 4,
  parameter int UIP_LEAD = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_32k,
  input  logic [2:0]        osc_ctl,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqw_en,
  input  logic              set_hold,
  output logic              sqw,
  output logic              periodic_pulse,
  output logic              update_strobe,
  output logic              update_in_progress,
  output logic              update_done
);

  osc_mode_e         mode;
  logic              run_entry;
  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_nxt;
  logic              wrap;

  rdu_mode_decode u_mode (
    .clk       (clk),
    .rst       (rst),
    .osc_ctl   (osc_ctl),
    .mode      (mode),
    .run_entry (run_entry)
  );

  rdu_chain #(.STAGES(STAGES)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_32k),
    .mode      (mode),
    .run_entry (run_entry),
    .cnt_q     (cnt_q),
    .cnt_nxt   (cnt_nxt),
    .wrap      (wrap)
  );

  rdu_tap_mux #(.STAGES(STAGES), .RATE_W(RATE_W)) u_taps (
    .clk            (clk),
    .rst            (rst),
    .cnt_q          (cnt_q),
    .cnt_nxt        (cnt_nxt),
    .rate_sel       (rate_sel),
    .sqw_en         (sqw_en),
    .sqw            (sqw),
    .periodic_pulse (periodic_pulse)
  );

  rdu_update_seq #(.STAGES(STAGES), .UIP_LEAD(UIP_LEAD)) u_upd (
    .clk                (clk),
    .rst                (rst),
    .cnt_nxt            (cnt_nxt),
    .wrap               (wrap),
    .running            (mode == OSC_RUN),
    .set_hold           (set_hold),
    .update_strobe      (update_strobe),
    .update_in_progress (update_in_progress),
    .update_done        (update_done)
  );

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (osc_ctl[2:1] == 2'b11) |=> (!update_strobe && !update_in_progress));  // R1
  AST_STROBE_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({update_strobe, update_done}));  // R9

endmodule

// File: tb/tb_rate_div_uip.sv
module tb_rate_div_uip;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_32k = 1'b1;
  logic [2:0] osc_ctl = 3'b010;
  logic [3:0] rate_sel = 4'd3;
  logic       sqw_en = 1'b1;
  logic       set_hold = 1'b0;
  logic       sqw, periodic_pulse, update_strobe, update_in_progress, update_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit gap_tick = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_run_prev = 0;
  bit e_sqw = 0, e_per = 0, e_upd = 0, e_uip = 0, e_done = 0;

  rate_div_uip dut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .osc_ctl(osc_ctl),
    .rate_sel(rate_sel), .sqw_en(sqw_en), .set_hold(set_hold),
    .sqw(sqw), .periodic_pulse(periodic_pulse), .update_strobe(update_strobe),
    .update_in_progress(update_in_progress), .update_done(update_done)
  );

  always #2 clk = ~clk;

  // frequency of each code from the rate table, bit index derived from it
  function automatic int tap_bit(input int code);
    int hz = (code == 1) ? 256 : (code == 2) ? 128 : (1 << (16 - code));
    int ratio = 32768 / hz;
    int b = 0;
    while ((1 << (b + 1)) < ratio) b++;
    return b;
  endfunction

  function automatic bit bit_at(input int v, input int code);
    if (code == 0) return 0;
    return ((v >> tap_bit(code)) & 1) != 0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_cnt = 0; m_run_prev = 0;
      e_sqw = 0; e_per = 0; e_upd = 0; e_uip = 0; e_done = 0;
    end else begin
      bit run, hold, wrapped;
      int old;
      run = (osc_ctl == 3'b010);
      hold = (osc_ctl[2:1] == 2'b11);
      wrapped = 0;
      old = m_cnt;
      if (hold) m_cnt = 0;
      else if (run && !m_run_prev) m_cnt = 16384;
      else if (run && tick_32k) begin
        wrapped = (m_cnt == 32767);
        m_cnt = (m_cnt + 1) % 32768;
      end
      m_run_prev = run;
      e_done = e_upd;
      e_upd  = wrapped && !set_hold;
      e_uip  = !set_hold && run && (m_cnt >= 32760 || wrapped);
      e_sqw  = sqw_en && bit_at(m_cnt, rate_sel);
      e_per  = bit_at(m_cnt, rate_sel) && !bit_at(old, rate_sel);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(sqw == e_sqw, "R6 sqw", sqw, e_sqw);
      check(periodic_pulse == e_per, "R5 periodic_pulse", periodic_pulse, e_per);
      check(update_strobe == e_upd, "R3 update_strobe", update_strobe, e_upd);
      check(update_in_progress == e_uip, "R7 update_in_progress", update_in_progress, e_uip);
      check(update_done == e_done, "R9 update_done", update_done, e_done);
    end
  end

  always @(negedge clk) begin
    if (gap_tick) tick_32k <= ~tick_32k;
    else          tick_32k <= 1'b1;
  end

  task automatic count_pulses(input int code, input int win, output int got);
    rate_sel = 4'(code);
    repeat (8) @(negedge clk);
    got = 0;
    repeat (win) begin
      @(negedge clk);
      if (periodic_pulse) got++;
    end
  endtask

  task automatic wait_strobe(output int at, output int uip_rise);
    bit prev_uip = update_in_progress;
    uip_rise = -1;
    forever begin
      @(negedge clk);
      if (update_in_progress && !prev_uip) uip_rise = cyc;
      prev_uip = update_in_progress;
      if (update_strobe) break;
    end
    at = cyc;
  endtask

  initial begin
    int entry, t1, t2, rise, got, n_upd, n_uip, n_per;
    bit frozen;
    repeat (4) @(negedge clk);
    check({sqw, periodic_pulse, update_strobe, update_in_progress, update_done} == 0,
          "R10 reset outputs", {sqw, periodic_pulse, update_strobe, update_in_progress, update_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    entry = cyc;

    // R4 rate measurements inside the first half second
    count_pulses(3, 1024, got);  check(got == 256, "R4 code3 8192Hz", got, 256);
    count_pulses(4, 1024, got);  check(got == 128, "R4 code4 4096Hz", got, 128);
    count_pulses(1, 1024, got);  check(got == 8,   "R4 code1 256Hz", got, 8);
    count_pulses(2, 1024, got);  check(got == 4,   "R4 code2 128Hz", got, 4);
    count_pulses(0, 1024, got);  check(got == 0,   "R4 code0 off", got, 0);
    check(sqw == 1'b0, "R4 code0 sqw low", sqw, 0);
    rate_sel = 4'd6;
    sqw_en = 1'b0;
    repeat (300) @(negedge clk);
    check(sqw == 1'b0, "R6 disabled sqw", sqw, 0);
    sqw_en = 1'b1;

    wait_strobe(t1, rise);
    check(t1 - entry == 16384, "R2 first update distance", t1 - entry, 16384);

    rate_sel = 4'd15;
    wait_strobe(t2, rise);
    check(t2 - t1 == 32768, "R3 update period", t2 - t1, 32768);
    check(t2 - rise == 8, "R7 warning lead", t2 - rise, 8);
    @(negedge clk);
    check(update_done == 1'b1, "R9 done after strobe", update_done, 1);

    // R8: hold input across a full second
    set_hold = 1'b1;
    n_upd = 0; n_uip = 0;
    repeat (32900) begin
      @(negedge clk);
      if (update_strobe || update_done) n_upd++;
      if (update_in_progress) n_uip++;
    end
    check(n_upd == 0, "R8 no transfer while set", n_upd, 0);
    check(n_uip == 0, "R8 no warning while set", n_uip, 0);
    set_hold = 1'b0;

    // R1: hold-in-reset code
    rate_sel = 4'd3;
    osc_ctl = 3'b111;
    n_per = 0; n_upd = 0;
    repeat (200) begin
      @(negedge clk);
      if (periodic_pulse) n_per++;
      if (update_strobe || update_in_progress) n_upd++;
    end
    check(n_per == 0 && sqw == 0, "R1 hold quiet", n_per + sqw, 0);
    check(n_upd == 0, "R1 hold no update", n_upd, 0);

    // R1: stop code freezes sqw
    osc_ctl = 3'b010;
    repeat (37) @(negedge clk);
    osc_ctl = 3'b001;
    @(negedge clk);
    frozen = sqw;
    n_per = 0; got = 0;
    repeat (100) begin
      @(negedge clk);
      if (periodic_pulse) n_per++;
      if (sqw != frozen) got++;
    end
    check(n_per == 0, "R1 stop no pulse", n_per, 0);
    check(got == 0, "R1 stop sqw frozen", got, 0);

    // R2 re-entry with a gapped tick
    gap_tick = 1'b1;
    rate_sel = 4'd9;
    osc_ctl = 3'b010;
    wait_strobe(t1, rise);
    check(update_strobe == 1'b1, "R2 gapped first update", update_strobe, 1);
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(180000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule